// File: doc/BRIEF.md
# Floating-Point Operand Unpacker

This unit turns a 128-bit register image into one operand in a common internal form. A format code tells the unit how to read the image: as a 32-bit or 64-bit two's-complement integer, or as a single, double or quad precision float. The internal form has four parts:

- a sign;
- a signed, unbiased exponent;
- a 128-bit mantissa, left-aligned so that the integer bit is bit 127;
- a class code.

Arithmetic stages downstream work on this one form and never see the source format.

The five formats share one datapath. Each float format gets its own field decoder, built by a generate loop. The two integer forms place their magnitude at the top of the mantissa with a fixed exponent. Denormals and integers then pass through a shared leading-zero counter and barrel shifter. The unit quiets a signalling NaN as it enters, gives it its own class, and raises an invalid-operation flag.

All outputs are registered. A small two-state machine tracks when a result is present:

- **ST_IDLE → ST_PRESENT** when an input strobe arrives.
- **ST_PRESENT → ST_PRESENT** when another strobe arrives back to back.
- **ST_PRESENT → ST_IDLE** when a cycle passes with no strobe.

Top module: `fpu_unpack`

## Requirements
- R1: `in_fmt` codes are 0 = 32-bit integer, 1 = 64-bit integer, 2 = single, 3 = double, 4 = quad. A strobe on `in_valid` produces `out_valid` high on the next cycle with that operand's result. With no strobe, `out_valid` falls one cycle later and the result outputs keep their values.
- R2: `out_sign` is always image bit 127, for every format, integers included.
- R3: `out_class` codes are 0 = zero, 1 = number, 2 = infinity, 3 = quiet NaN, 4 = signalling NaN. The zero class results from a float whose exponent field and fraction are both zero, or from an integer equal to zero. In that case the mantissa and the exponent are zero.
- R4: Float fields sit directly below bit 127: the exponent field first, then the fraction. Exponent/fraction widths are 8/23 (single), 11/52 (double) and 15/112 (quad), and the bias is 2^(width-1)-1. A normal float puts the fraction just below bit 127 and sets bit 127 to one. Its exponent is the field value minus the bias, and its class is number.
- R5: A zero exponent field with a nonzero fraction is a denormal. No implied one is added. The mantissa is shifted left until bit 127 is one, and the exponent is 1 minus the bias minus the shift. The class is number.
- R6: An all-ones exponent field with a zero fraction gives class infinity, a zero mantissa and an exponent of bias+1.
- R7: An all-ones exponent field with a nonzero fraction whose top bit (mantissa bit 126) is set gives quiet NaN. The fraction is kept unchanged, bit 127 is zero, and the invalid flag stays low.
- R8: An all-ones exponent field with a nonzero fraction whose top bit is clear gives signalling NaN. The unit sets mantissa bit 126, keeps the other fraction bits, and raises `out_invalid`. No other input raises the invalid flag.
- R9: The 32-bit integer is image bits 95:64. A negative value is converted to its magnitude, the magnitude is normalized to bit 127, and the exponent is 31 minus the shift.
- R10: The 64-bit integer is image bits 127:64. It is converted to a magnitude and normalized the same way, with exponent 63 minus the shift.
- R11: Format codes 5 to 7 raise `out_fmt_err` and give class zero with a zero mantissa and exponent. `out_invalid` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input strobe |
| in_fmt | input | 3 | Source format code |
| in_image | input | 128 | Register image |
| out_valid | output | 1 | Result present |
| out_sign | output | 1 | Operand sign |
| out_exp | output | 18 | Signed unbiased exponent |
| out_mant | output | 128 | Mantissa, integer bit at 127 |
| out_class | output | 3 | Class code |
| out_invalid | output | 1 | Signalling-NaN invalid flag |
| out_fmt_err | output | 1 | Unsupported format code |

## Verification
The hardest case to reach is the far end of the normalizer. Only a denormal whose single set fraction bit is the least significant one drives the full shift and the lowest exponent. The bench builds these minimum denormals directly for single, double and quad, so the shift distances are 23, 52 and 112. The integer path is also checked at both ends: a most-negative value that needs no shift, and a value of one that needs the largest shift. The bench also applies a signalling NaN with only the lowest fraction bit set, so that quieting has to add bit 126 while keeping bit 104.

// File: rtl/fpu_unpack_pkg.sv
package fpu_unpack_pkg;

    typedef enum logic [2:0] {
        FMT_I32  = 3'd0,
        FMT_I64  = 3'd1,
        FMT_SGL  = 3'd2,
        FMT_DBL  = 3'd3,
        FMT_QUAD = 3'd4
    } fp_fmt_e;

    typedef enum logic [2:0] {
        CLS_ZERO = 3'd0,
        CLS_NUM  = 3'd1,
        CLS_INF  = 3'd2,
        CLS_QNAN = 3'd3,
        CLS_SNAN = 3'd4
    } fp_class_e;

    typedef enum logic {
        ST_IDLE    = 1'b0,
        ST_PRESENT = 1'b1
    } out_state_e;

    localparam int NUM_FMT = 5;

endpackage

// File: rtl/fpu_float_field.sv
module fpu_float_field
    import fpu_unpack_pkg::*;
#(
    parameter int EW    = 8,
    parameter int FW    = 23,
    parameter int MW    = 128,
    parameter int XW    = 18
) (
    input  logic [EW+FW-1:0]    body,
    output logic signed [XW-1:0] exp_o,
    output logic [MW-1:0]       mant_o,
    output fp_class_e           cls_o,
    output logic                norm_o
);
    localparam int PAD  = MW - 1 - FW;
    localparam int BIAS = (1 << (EW - 1)) - 1;
    localparam logic [EW-1:0] EMAX = {EW{1'b1}};

    logic [EW-1:0] efield;
    logic [FW-1:0] frac;
    logic          frac_nz;

    assign efield  = body[EW+FW-1 -: EW];
    assign frac    = body[FW-1:0];
    assign frac_nz = |frac;

    always_comb begin
        exp_o  = XW'(efield) - XW'(BIAS);
        mant_o = {1'b1, frac, {PAD{1'b0}}};
        cls_o  = CLS_NUM;
        norm_o = 1'b0;
        if (efield == '0) begin
            if (!frac_nz) begin
                exp_o  = '0;
                mant_o = '0;
                cls_o  = CLS_ZERO;
            end else begin
                exp_o  = XW'(1) - XW'(BIAS);
                mant_o = {1'b0, frac, {PAD{1'b0}}};
                norm_o = 1'b1;
            end
        end else if (efield == EMAX) begin
            if (!frac_nz) begin
                mant_o = '0;
                cls_o  = CLS_INF;
            end else if (frac[FW-1]) begin
                mant_o = {1'b0, frac, {PAD{1'b0}}};
                cls_o  = CLS_QNAN;
            end else begin
                mant_o = {2'b01, frac[FW-2:0], {PAD{1'b0}}};
                cls_o  = CLS_SNAN;
            end
        end
    end
endmodule

// File: rtl/fpu_int_field.sv
module fpu_int_field
    import fpu_unpack_pkg::*;
#(
    parameter int IW = 32,
    parameter int MW = 128,
    parameter int XW = 18
) (
    input  logic [IW-1:0]        val,
    output logic signed [XW-1:0] exp_o,
    output logic [MW-1:0]        mant_o,
    output fp_class_e            cls_o,
    output logic                 norm_o
);
    logic [IW-1:0] mag;

    assign mag = val[IW-1] ? (~val + IW'(1)) : val;

    always_comb begin
        if (val == '0) begin
            exp_o  = '0;
            mant_o = '0;
            cls_o  = CLS_ZERO;
            norm_o = 1'b0;
        end else begin
            exp_o  = XW'(IW - 1);
            mant_o = {mag, {(MW-IW){1'b0}}};
            cls_o  = CLS_NUM;
            norm_o = 1'b1;
        end
    end
endmodule

// File: rtl/fpu_norm_shift.sv
module fpu_norm_shift #(
    parameter int MW = 128,
    parameter int XW = 18
) (
    input  logic [MW-1:0]        mant_i,
    input  logic signed [XW-1:0] exp_i,
    output logic [MW-1:0]        mant_o,
    output logic signed [XW-1:0] exp_o
);
    localparam int CW = $clog2(MW + 1);

    logic [CW-1:0] lz;
    logic          seen;

    always_comb begin
        lz   = '0;
        seen = 1'b0;
        for (int i = MW - 1; i >= 0; i--) begin
            if (!seen) begin
                if (mant_i[i]) seen = 1'b1;
                else           lz   = lz + CW'(1);
            end
        end
    end

    assign mant_o = mant_i << lz;
    assign exp_o  = exp_i - XW'(lz);
endmodule

// File: rtl/fpu_unpack.sv
module fpu_unpack
    import fpu_unpack_pkg::*;
#(
    parameter int MANT_W = 128,
    parameter int EXP_W  = 18
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic [2:0]              in_fmt,
    input  logic [MANT_W-1:0]       in_image,
    output logic                    out_valid,
    output logic                    out_sign,
    output logic signed [EXP_W-1:0] out_exp,
    output logic [MANT_W-1:0]       out_mant,
    output logic [2:0]              out_class,
    output logic                    out_invalid,
    output logic                    out_fmt_err
);
    localparam int W0_TOP = MANT_W - 1;

    logic signed [EXP_W-1:0] f_exp  [NUM_FMT];
    logic [MANT_W-1:0]       f_mant [NUM_FMT];
    fp_class_e               f_cls  [NUM_FMT];
    logic                    f_norm [NUM_FMT];

    genvar g;
    generate
        for (g = 0; g < NUM_FMT; g++) begin : g_fmt
            if (g < 2) begin : g_int
                localparam int IW = (g == 0) ? 32 : 64;
                localparam int LO = (g == 0) ? MANT_W - 64 : MANT_W - 64;
                fpu_int_field #(.IW(IW), .MW(MANT_W), .XW(EXP_W)) u_int (
                    .val    (in_image[LO+IW-1 -: IW]),
                    .exp_o  (f_exp[g]),
                    .mant_o (f_mant[g]),
                    .cls_o  (f_cls[g]),
                    .norm_o (f_norm[g])
                );
            end else begin : g_flt
                localparam int EW = (g == 2) ? 8  : (g == 3) ? 11 : 15;
                localparam int FW = (g == 2) ? 23 : (g == 3) ? 52 : 112;
                fpu_float_field #(.EW(EW), .FW(FW), .MW(MANT_W), .XW(EXP_W)) u_flt (
                    .body   (in_image[W0_TOP-1 -: EW+FW]),
                    .exp_o  (f_exp[g]),
                    .mant_o (f_mant[g]),
                    .cls_o  (f_cls[g]),
                    .norm_o (f_norm[g])
                );
            end
        end
    endgenerate

    logic signed [EXP_W-1:0] sel_exp;
    logic [MANT_W-1:0]       sel_mant;
    fp_class_e               sel_cls;
    logic                    sel_norm;
    logic                    sel_err;

    always_comb begin
        sel_exp  = '0;
        sel_mant = '0;
        sel_cls  = CLS_ZERO;
        sel_norm = 1'b0;
        sel_err  = 1'b1;
        for (int k = 0; k < NUM_FMT; k++) begin
            if (in_fmt == 3'(k)) begin
                sel_exp  = f_exp[k];
                sel_mant = f_mant[k];
                sel_cls  = f_cls[k];
                sel_norm = f_norm[k];
                sel_err  = 1'b0;
            end
        end
    end

    logic [MANT_W-1:0]       nrm_mant;
    logic signed [EXP_W-1:0] nrm_exp;

    fpu_norm_shift #(.MW(MANT_W), .XW(EXP_W)) u_norm (
        .mant_i (sel_mant),
        .exp_i  (sel_exp),
        .mant_o (nrm_mant),
        .exp_o  (nrm_exp)
    );

    out_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (in_valid)  state_d = ST_PRESENT;
            ST_PRESENT: if (!in_valid) state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_sign    <= 1'b0;
            out_exp     <= '0;
            out_mant    <= '0;
            out_class   <= CLS_ZERO;
            out_invalid <= 1'b0;
            out_fmt_err <= 1'b0;
        end else if (in_valid) begin
            out_sign    <= in_image[W0_TOP];
            out_exp     <= sel_norm ? nrm_exp  : sel_exp;
            out_mant    <= sel_norm ? nrm_mant : sel_mant;
            out_class   <= sel_cls;
            out_invalid <= (sel_cls == CLS_SNAN);
            out_fmt_err <= sel_err;
        end
    end

    assign out_valid = (state_q == ST_PRESENT);

    // R1: result appears one cycle after the strobe and drops after an idle cycle
    assert_strobe_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    assert_idle_drop_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(out_mant) && $stable(out_class)));
    // R2: sign follows image bit 127
    assert_sign_src_R2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (out_sign == $past(in_image[W0_TOP])));
    // R5 R9 R10: a number always leaves with its integer bit set
    assert_norm_lead_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_class == CLS_NUM) |-> out_mant[MANT_W-1]);
    // R8: invalid only for signalling NaN, which is quieted
    assert_snan_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        out_invalid |-> (out_class == CLS_SNAN && out_mant[MANT_W-2] && !out_mant[MANT_W-1]));
    // R11: bad format code forces the zero class
    assert_fmt_err_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_fmt > 3'd4) |=> (out_fmt_err && out_class == CLS_ZERO && out_mant == '0));
endmodule

// File: tb/test_fpu_unpack.sv
module test_fpu_unpack;
    logic               clk = 1'b0;
    logic               rst_n;
    logic               in_valid;
    logic [2:0]         in_fmt;
    logic [127:0]       in_image;
    logic               out_valid;
    logic               out_sign;
    logic signed [17:0] out_exp;
    logic [127:0]       out_mant;
    logic [2:0]         out_class;
    logic               out_invalid;
    logic               out_fmt_err;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2 clk = ~clk;

    fpu_unpack i_fpu_unpack (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_fmt(in_fmt),
        .in_image(in_image), .out_valid(out_valid), .out_sign(out_sign),
        .out_exp(out_exp), .out_mant(out_mant), .out_class(out_class),
        .out_invalid(out_invalid), .out_fmt_err(out_fmt_err)
    );

    localparam logic [127:0] ONE = 128'h1;

    task automatic check(input string tag, input logic [2:0] cls, input logic sgn,
                         input logic signed [17:0] ex, input logic [127:0] mt,
                         input logic inv, input logic err);
        n_tests++;
        if (out_valid !== 1'b1 || out_class !== cls || out_sign !== sgn || out_exp !== ex ||
            out_mant !== mt || out_invalid !== inv || out_fmt_err !== err) begin
            n_fail++;
            $display("FAIL %s: got v=%b cls=%0d s=%b exp=%0d mant=%h inv=%b err=%b; exp v=1 cls=%0d s=%b exp=%0d mant=%h inv=%b err=%b",
                     tag, out_valid, out_class, out_sign, out_exp, out_mant, out_invalid, out_fmt_err,
                     cls, sgn, ex, mt, inv, err);
        end
    endtask

    task automatic apply(input logic [2:0] fmt, input logic [127:0] img);
        @(negedge clk);
        in_valid = 1'b1;
        in_fmt   = fmt;
        in_image = img;
        @(negedge clk);
        in_valid = 1'b0;
        in_image = '0;
    endtask

    task automatic t_reset;
        n_tests++;
        if (out_valid !== 1'b0 || out_class !== 3'd0 || out_mant !== '0 || out_invalid !== 1'b0) begin
            n_fail++;
            $display("FAIL R1 reset: v=%b cls=%0d mant=%h inv=%b expected all zero",
                     out_valid, out_class, out_mant, out_invalid);
        end
    endtask

    task automatic t_single;
        apply(3'd2, {32'h3F800000, 96'h0});
        check("R4 single 1.0", 3'd1, 1'b0, 18'sd0, ONE << 127, 1'b0, 1'b0);
        apply(3'd2, {32'hC0400000, 96'h0});
        check("R4 R2 single -3.0", 3'd1, 1'b1, 18'sd1, 128'h3 << 126, 1'b0, 1'b0);
        apply(3'd2, {32'h00000001, 96'h0});
        check("R5 single min denormal", 3'd1, 1'b0, -18'sd149, ONE << 127, 1'b0, 1'b0);
        apply(3'd2, {32'h80400000, 96'h0});
        check("R5 single top denormal", 3'd1, 1'b1, -18'sd127, ONE << 127, 1'b0, 1'b0);
        apply(3'd2, {32'h80000000, 96'h0});
        check("R3 single -0", 3'd0, 1'b1, 18'sd0, '0, 1'b0, 1'b0);
        apply(3'd2, {32'h7F800000, 96'h0});
        check("R6 single inf", 3'd2, 1'b0, 18'sd128, '0, 1'b0, 1'b0);
        apply(3'd2, {32'h7FC00001, 96'h0});
        check("R7 single qnan", 3'd3, 1'b0, 18'sd128, (ONE << 126) | (ONE << 104), 1'b0, 1'b0);
        apply(3'd2, {32'h7F800001, 96'h0});
        check("R8 single snan", 3'd4, 1'b0, 18'sd128, (ONE << 126) | (ONE << 104), 1'b1, 1'b0);
    endtask

    task automatic t_double;
        apply(3'd3, {64'h3FF8000000000000, 64'h0});
        check("R4 double 1.5", 3'd1, 1'b0, 18'sd0, 128'h3 << 126, 1'b0, 1'b0);
        apply(3'd3, {64'h0000000000000001, 64'hFFFF});
        check("R5 double min denormal", 3'd1, 1'b0, -18'sd1074, ONE << 127, 1'b0, 1'b0);
        apply(3'd3, {64'hFFF0000000000002, 64'h0});
        check("R8 double snan", 3'd4, 1'b1, 18'sd1024, (ONE << 126) | (ONE << 76), 1'b1, 1'b0);
        apply(3'd3, {64'hFFF0000000000000, 64'h0});
        check("R6 double -inf", 3'd2, 1'b1, 18'sd1024, '0, 1'b0, 1'b0);
    endtask

    task automatic t_quad;
        apply(3'd4, {16'h4000, 112'h0});
        check("R4 quad 2.0", 3'd1, 1'b0, 18'sd1, ONE << 127, 1'b0, 1'b0);
        apply(3'd4, {16'h0000, 112'h1});
        check("R5 quad min denormal", 3'd1, 1'b0, -18'sd16494, ONE << 127, 1'b0, 1'b0);
        apply(3'd4, {16'h7FFF, 112'h0});
        check("R6 quad inf", 3'd2, 1'b0, 18'sd16384, '0, 1'b0, 1'b0);
        apply(3'd4, {16'h7FFF, 1'b1, 111'h0});
        check("R7 quad qnan", 3'd3, 1'b0, 18'sd16384, ONE << 126, 1'b0, 1'b0);
    endtask

    task automatic t_int;
        apply(3'd0, {32'h80000000, 32'hFFFFFFFF, 64'h0});
        check("R9 R2 int32 -1", 3'd1, 1'b1, 18'sd0, ONE << 127, 1'b0, 1'b0);
        apply(3'd0, {32'h00000000, 32'h00000005, 64'h0});
        check("R9 int32 5", 3'd1, 1'b0, 18'sd2, 128'h5 << 125, 1'b0, 1'b0);
        apply(3'd0, {32'h00000000, 32'h80000000, 64'h0});
        check("R9 int32 most negative", 3'd1, 1'b0, 18'sd31, ONE << 127, 1'b0, 1'b0);
        apply(3'd0, {32'h00000000, 32'h00000000, 64'hFFFF});
        check("R3 int32 zero", 3'd0, 1'b0, 18'sd0, '0, 1'b0, 1'b0);
        apply(3'd1, {64'h0000000100000000, 64'h0});
        check("R10 int64 2^32", 3'd1, 1'b0, 18'sd32, ONE << 127, 1'b0, 1'b0);
        apply(3'd1, {64'hFFFFFFFFFFFFFFFE, 64'h0});
        check("R10 int64 -2", 3'd1, 1'b1, 18'sd1, ONE << 127, 1'b0, 1'b0);
    endtask

    task automatic t_fmt_err;
        apply(3'd6, {32'h3F800000, 96'h0});
        check("R11 bad format", 3'd0, 1'b0, 18'sd0, '0, 1'b0, 1'b1);
    endtask

    task automatic t_hold;
        apply(3'd2, {32'h3F800000, 96'h0});
        @(negedge clk);
        n_tests++;
        if (out_valid !== 1'b0 || out_mant !== (ONE << 127) || out_class !== 3'd1) begin
            n_fail++;
            $display("FAIL R1 hold: v=%b mant=%h cls=%0d expected v=0 mant=%h cls=1",
                     out_valid, out_mant, out_class, ONE << 127);
        end
    endtask

    initial begin
        #800000;
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: run did not complete, expected finish");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n    = 1'b0;
        in_valid = 1'b0;
        in_fmt   = 3'd0;
        in_image = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_single();
        t_double();
        t_quad();
        t_int();
        t_fmt_err();
        t_hold();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule